// File: doc/BRIEF.md
# Edge-Triggered Offset Calibration Controller

This block owns the 10-bit offset correction word of a differential field sensor front end. After reset, and after every forced restart, it finds a starting offset by a successive approximation search against an external comparator. The search settles one bit per step, starting at the MSB, and each step lasts a fixed number of clocks. While the search runs, the block holds the switching output locked.

Once the search finishes, the block runs off the switching edges of the sensor output. On each edge it forms a correction from the most recent peak pair: the sum of the latest minimum and maximum, minus the mid-scale sum, scaled by the current gain index. The correction then has to pass a set of gates before it moves the offset. A hysteretic fine mode limits it to single-LSB steps. A history filter lets a full correction through only when two corrections in a row agree. Edge-count blanking follows every gain change and every offset move. A shift may only land on the edge whose direction matches the sign of the shift.

Two supervisors run beside the offset path. One restarts the whole calibration when the output has stopped switching. The other asks the gain stage to step down when edges keep arriving without any new peak.

Top module: `offset_cal_ctrl`

## Requirements
- R1: Out of reset, and after a restart, `lock_o` is 1 and `offset_o` shows the trial word. The trial word starts at 0x200. Each step lasts `STEP_CYC` clocks. On the last clock of a step, the bit under test is kept if `cmp_i`=1 and cleared otherwise, and the next lower bit is set. When bit 0 has been decided, `lock_o` falls on the next clock and `offset_o` holds the search result.
- R2: The correction is min+max−256. For gain index g≥3 it is shifted left by g−3. For g<3 it is shifted right arithmetically by 3−g.
- R3: A correction with magnitude below 8 leaves the offset unchanged. A magnitude from 8 to 16 moves the offset by one LSB in the sign of the correction. Above 16 the full correction may apply.
- R4: Fine mode is entered when max−min is below 8 and left when max−min exceeds 16. Between those two values the mode holds. The mode is re-evaluated on each qualifying edge, and the new value governs that same edge. In fine mode, any correction of magnitude 8 or more moves the offset by one LSB only.
- R5: A full correction applies only if the correction computed on the previous edge that had a valid peak had magnitude above 8 and the same sign. If it did not, the offset does not move. A gain change clears this history.
- R6: A positive shift applies only on a rising edge (`edge_rise_i`=1). A negative shift applies only on a falling edge. A shift offered on the other edge has no effect.
- R7: A gain change blocks updates on the two following edges, and the third edge may update again. An offset update blocks the next edge, and the second edge may update again. An edge in the same cycle as a gain change never updates.
- R8: An update needs `min_vld_i` or `max_vld_i`. The first update that passes all gates after a search is discarded.
- R9: The offset saturates at 0 and at 0x3FF.
- R10: After `WDOG_CYC` consecutive unlocked clocks without an edge, `restart_o` pulses for one clock and `lock_o` rises in that same clock. A new search then starts from 0x200.
- R11: On the 16th consecutive edge that arrives without `peak_i`, `gain_dec_o` pulses for one clock on the following cycle and the count restarts. `peak_i` clears the count. Neither of these changes the offset.
- R12: An accepted update appears on `offset_o` on the clock after the edge cycle. Edges that arrive while `lock_o`=1 have no effect on the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Comparator: input at or above trial offset |
| edge_i | input | 1 | One-cycle pulse per output switching event |
| edge_rise_i | input | 1 | Direction of the edge, 1 = rising |
| min_i | input | DATA_W | Latest minimum sample |
| max_i | input | DATA_W | Latest maximum sample |
| min_vld_i | input | 1 | Minimum is valid |
| max_vld_i | input | 1 | Maximum is valid |
| peak_i | input | 1 | Pulse: a new minimum or maximum was found |
| gain_i | input | GAIN_W | Current gain index |
| gain_chg_i | input | 1 | Pulse: gain index changed |
| offset_o | output | OFS_W | Offset correction word |
| lock_o | output | 1 | Hold the switching output |
| restart_o | output | 1 | Pulse: re-initialise gain, search restarted |
| gain_dec_o | output | 1 | Pulse: step gain down by one |

## Verification
A corrupt blanking counter, first-update flag or history bit stays hidden until the next edge that carries a non-zero correction. At that point the offset moves on the wrong edge, or fails to move on the right one, one clock after the edge. A fault in the search logic shows as a wrong settled word on the first clock after the lock drops. A watchdog or peak-count fault shows as a restart or gain-decrement pulse that arrives early, late or not at all. Because the reference model is compared on every clock, each of these faults is caught on the first clock in which it reaches a port.

// File: rtl/ofs_cal_pkg.sv
package ofs_cal_pkg;
  localparam int unsigned UNITY_GAIN = 3;   // gain index with no shift
  localparam int unsigned STEP_LO    = 8;   // below: no move
  localparam int unsigned STEP_HI    = 16;  // up to: single lsb
  localparam int unsigned FILT_MIN   = 8;   // history must exceed this
  localparam int unsigned FINE_IN    = 8;   // span below: enter fine
  localparam int unsigned FINE_OUT   = 16;  // span above: leave fine
  localparam int unsigned BLANK_GAIN = 3;   // edge index re-enabled after gain change
  localparam int unsigned BLANK_OFS  = 2;   // edge index re-enabled after update
endpackage

// File: rtl/ofs_sar_search.sv
module ofs_sar_search #(
  parameter int unsigned OFS_W    = 10,
  parameter int unsigned STEP_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             active_o,
  output logic             done_o,
  output logic [OFS_W-1:0] trial_o,
  output logic [OFS_W-1:0] result_o
);
  localparam int unsigned STEP_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [OFS_W-1:0] TOP_BIT = OFS_W'(1) << (OFS_W - 1);

  logic             active_q;
  logic [STEP_W-1:0] step_q;
  logic [OFS_W-1:0] mask_q, trial_q, decided;
  logic             step_end;

  assign step_end = (step_q == STEP_W'(STEP_CYC - 1));
  assign decided  = cmp_i ? trial_q : (trial_q & ~mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      mask_q   <= TOP_BIT;
      trial_q  <= TOP_BIT;
      step_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      mask_q   <= TOP_BIT;
      trial_q  <= TOP_BIT;
      step_q   <= '0;
    end else if (active_q) begin
      if (step_end) begin
        step_q  <= '0;
        trial_q <= decided | (mask_q >> 1);
        mask_q  <= mask_q >> 1;
        if (mask_q[0]) active_q <= 1'b0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign done_o   = active_q && step_end && mask_q[0];
  assign trial_o  = trial_q;
  assign result_o = decided;
endmodule

// File: rtl/ofs_update_calc.sv
module ofs_update_calc
  import ofs_cal_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GAIN_W = 3,
  parameter int unsigned CORR_W = 14
) (
  input  logic [DATA_W-1:0]        min_i,
  input  logic [DATA_W-1:0]        max_i,
  input  logic [GAIN_W-1:0]        gain_i,
  input  logic                     fine_q_i,
  input  logic                     hist_big_i,
  input  logic                     hist_neg_i,
  output logic signed [CORR_W-1:0] delta_o,
  output logic                     neg_o,
  output logic                     big_o,
  output logic                     nz_o,
  output logic                     fine_nx_o
);
  localparam int unsigned SUM_W = DATA_W + 2;

  logic signed [SUM_W-1:0]  raw;
  logic signed [CORR_W-1:0] ext, scaled;
  logic [CORR_W-1:0]        mag;
  logic [DATA_W-1:0]        span;

  always_comb begin
    raw = $signed({2'b00, min_i} + {2'b00, max_i} - SUM_W'(2 ** DATA_W));
    ext = {{(CORR_W - SUM_W){raw[SUM_W-1]}}, raw};
    if (gain_i >= GAIN_W'(UNITY_GAIN)) scaled = ext <<< (gain_i - GAIN_W'(UNITY_GAIN));
    else                               scaled = ext >>> (GAIN_W'(UNITY_GAIN) - gain_i);
    neg_o = scaled[CORR_W-1];
    mag   = neg_o ? $unsigned(-scaled) : $unsigned(scaled);
    span  = (max_i > min_i) ? (max_i - min_i) : '0;
    if (span < DATA_W'(FINE_IN))       fine_nx_o = 1'b1;
    else if (span > DATA_W'(FINE_OUT)) fine_nx_o = 1'b0;
    else                               fine_nx_o = fine_q_i;
    if (mag < CORR_W'(STEP_LO))                          delta_o = '0;
    else if (fine_nx_o || (mag <= CORR_W'(STEP_HI)))     delta_o = neg_o ? '1 : CORR_W'(1);
    else if (hist_big_i && (hist_neg_i == neg_o))        delta_o = scaled;
    else                                                 delta_o = '0;
  end

  assign big_o = mag > CORR_W'(FILT_MIN);
  assign nz_o  = |delta_o;
endmodule

// File: rtl/ofs_edge_gate.sv
module ofs_edge_gate
  import ofs_cal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic run_i,
  input  logic edge_i,
  input  logic rise_i,
  input  logic gain_chg_i,
  input  logic peak_vld_i,
  input  logic fine_nx_i,
  input  logic big_i,
  input  logic neg_i,
  input  logic nz_i,
  output logic fine_o,
  output logic hist_big_o,
  output logic hist_neg_o,
  output logic apply_o
);
  localparam int unsigned BLK_W = $clog2(BLANK_GAIN);

  logic [BLK_W-1:0] blank_q;
  logic first_q, fine_q, hbig_q, hneg_q;
  logic cand, pass;

  // shift sign must match edge direction
  assign cand    = peak_vld_i && nz_i && (neg_i != rise_i);
  assign pass    = run_i && edge_i && !gain_chg_i && (blank_q == '0) && cand;
  assign apply_o = pass && !first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_q <= '0;
      first_q <= 1'b1;
      fine_q  <= 1'b0;
      hbig_q  <= 1'b0;
      hneg_q  <= 1'b0;
    end else if (init_i) begin
      blank_q <= '0;
      first_q <= 1'b1;
      fine_q  <= 1'b0;
      hbig_q  <= 1'b0;
      hneg_q  <= 1'b0;
    end else if (run_i) begin
      if (gain_chg_i) begin
        blank_q <= BLK_W'(BLANK_GAIN - 1);
        hbig_q  <= 1'b0;
      end else if (edge_i) begin
        if (peak_vld_i) begin
          fine_q <= fine_nx_i;
          hbig_q <= big_i;
          hneg_q <= neg_i;
        end
        if (blank_q != '0) blank_q <= blank_q - 1'b1;
        else if (cand) begin
          if (first_q) first_q <= 1'b0;
          else         blank_q <= BLK_W'(BLANK_OFS - 1);
        end
      end
    end
  end

  assign fine_o     = fine_q;
  assign hist_big_o = hbig_q;
  assign hist_neg_o = hneg_q;
endmodule

// File: rtl/ofs_supervisor.sv
module ofs_supervisor #(
  parameter int unsigned WDOG_CYC     = 1 << 20,
  parameter int unsigned NOPEAK_EDGES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic edge_i,
  input  logic peak_i,
  output logic restart_req_o,
  output logic gain_dec_o
);
  localparam int unsigned WD_W = $clog2(WDOG_CYC);
  localparam int unsigned NP_W = $clog2(NOPEAK_EDGES);

  logic [WD_W-1:0] wd_q;
  logic [NP_W-1:0] np_q;
  logic            gdec_q;

  assign restart_req_o = run_i && !edge_i && (wd_q == WD_W'(WDOG_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_q   <= '0;
      np_q   <= '0;
      gdec_q <= 1'b0;
    end else if (!run_i || restart_req_o) begin
      wd_q   <= '0;
      np_q   <= '0;
      gdec_q <= 1'b0;
    end else begin
      wd_q   <= edge_i ? '0 : wd_q + 1'b1;
      gdec_q <= 1'b0;
      if (peak_i) np_q <= '0;
      else if (edge_i) begin
        if (np_q == NP_W'(NOPEAK_EDGES - 1)) begin
          np_q   <= '0;
          gdec_q <= 1'b1;
        end else begin
          np_q <= np_q + 1'b1;
        end
      end
    end
  end

  assign gain_dec_o = gdec_q;
endmodule

// File: rtl/offset_cal_ctrl.sv
module offset_cal_ctrl
  import ofs_cal_pkg::*;
#(
  parameter int unsigned OFS_W        = 10,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned GAIN_W       = 3,
  parameter int unsigned STEP_CYC     = 4,
  parameter int unsigned WDOG_CYC     = 1 << 20,
  parameter int unsigned NOPEAK_EDGES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_i,
  input  logic              edge_i,
  input  logic              edge_rise_i,
  input  logic [DATA_W-1:0] min_i,
  input  logic [DATA_W-1:0] max_i,
  input  logic              min_vld_i,
  input  logic              max_vld_i,
  input  logic              peak_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic              gain_chg_i,
  output logic [OFS_W-1:0]  offset_o,
  output logic              lock_o,
  output logic              restart_o,
  output logic              gain_dec_o
);
  localparam int unsigned CORR_W = DATA_W + 2 + (2 ** GAIN_W - 1 - UNITY_GAIN);
  localparam int unsigned WIDE_W = ((CORR_W > OFS_W) ? CORR_W : OFS_W) + 2;

  logic              sar_active, sar_done, run, restart_req, restart_q;
  logic [OFS_W-1:0]  sar_trial, sar_result, run_ofs_q, sat_ofs;
  logic signed [CORR_W-1:0] delta;
  logic              neg, big, nz, fine_nx, fine_q, hist_big, hist_neg, apply;
  logic signed [WIDE_W-1:0] sum_w;

  assign run = !sar_active;

  ofs_sar_search #(.OFS_W(OFS_W), .STEP_CYC(STEP_CYC)) u_sar (
    .clk_i, .rst_ni, .start_i(restart_req), .cmp_i,
    .active_o(sar_active), .done_o(sar_done), .trial_o(sar_trial), .result_o(sar_result)
  );

  ofs_update_calc #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .CORR_W(CORR_W)) u_calc (
    .min_i, .max_i, .gain_i, .fine_q_i(fine_q), .hist_big_i(hist_big), .hist_neg_i(hist_neg),
    .delta_o(delta), .neg_o(neg), .big_o(big), .nz_o(nz), .fine_nx_o(fine_nx)
  );

  ofs_edge_gate u_gate (
    .clk_i, .rst_ni, .init_i(sar_done), .run_i(run), .edge_i, .rise_i(edge_rise_i),
    .gain_chg_i, .peak_vld_i(min_vld_i | max_vld_i), .fine_nx_i(fine_nx), .big_i(big),
    .neg_i(neg), .nz_i(nz), .fine_o(fine_q), .hist_big_o(hist_big), .hist_neg_o(hist_neg),
    .apply_o(apply)
  );

  ofs_supervisor #(.WDOG_CYC(WDOG_CYC), .NOPEAK_EDGES(NOPEAK_EDGES)) u_sup (
    .clk_i, .rst_ni, .run_i(run), .edge_i, .peak_i,
    .restart_req_o(restart_req), .gain_dec_o
  );

  // saturating add
  always_comb begin
    sum_w = $signed({{(WIDE_W - OFS_W){1'b0}}, run_ofs_q})
          + $signed({{(WIDE_W - CORR_W){delta[CORR_W-1]}}, delta});
    if (sum_w[WIDE_W-1])                sat_ofs = '0;
    else if (|sum_w[WIDE_W-2:OFS_W])    sat_ofs = '1;
    else                                sat_ofs = sum_w[OFS_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_ofs_q <= '0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= restart_req;
      if (sar_done)   run_ofs_q <= sar_result;
      else if (apply) run_ofs_q <= sat_ofs;
    end
  end

  assign offset_o  = sar_active ? sar_trial : run_ofs_q;
  assign lock_o    = sar_active;
  assign restart_o = restart_q;
endmodule

// File: rtl/offset_cal_ctrl_chk.sv
module offset_cal_ctrl_chk #(
  parameter int unsigned OFS_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             edge_i,
  input logic             edge_rise_i,
  input logic             gain_chg_i,
  input logic [OFS_W-1:0] offset_o,
  input logic             lock_o,
  input logic             restart_o,
  input logic             gain_dec_o
);
  AST_HOLD_WITHOUT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_o && !$past(lock_o) && !$past(edge_i)) |-> (offset_o == $past(offset_o)))
    else $error("offset moved without edge"); // R12
  AST_UP_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_o && !$past(lock_o) && (offset_o > $past(offset_o))) |-> $past(edge_rise_i))
    else $error("positive shift on falling edge"); // R6
  AST_DOWN_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_o && !$past(lock_o) && (offset_o < $past(offset_o))) |-> !$past(edge_rise_i))
    else $error("negative shift on rising edge"); // R6
  AST_GAIN_CHG_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_o && !$past(lock_o) && $past(gain_chg_i)) |-> (offset_o == $past(offset_o)))
    else $error("update in gain change cycle"); // R7
  AST_RESTART_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> lock_o)
    else $error("restart without lock"); // R10
  AST_RESTART_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o)
    else $error("restart longer than one clock"); // R10
  AST_GAIN_DEC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_dec_o |=> !gain_dec_o)
    else $error("gain decrement longer than one clock"); // R11
  AST_NO_DEC_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> !gain_dec_o)
    else $error("gain decrement while locked"); // R11
endmodule

bind offset_cal_ctrl offset_cal_ctrl_chk #(.OFS_W(OFS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(edge_i), .edge_rise_i(edge_rise_i),
  .gain_chg_i(gain_chg_i), .offset_o(offset_o), .lock_o(lock_o),
  .restart_o(restart_o), .gain_dec_o(gain_dec_o)
);

// File: tb/offset_cal_ctrl_tb.sv
module offset_cal_ctrl_tb;
  localparam int STEP = 2;
  localparam int WD   = 300;
  localparam int NP   = 16;
  localparam int MAXO = 1023;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmp = 1'b0, edge_p = 1'b0, rise = 1'b0, vmin = 1'b0, vmax = 1'b0, peak = 1'b0, gchg = 1'b0;
  logic [7:0] mn = 8'h80, mx = 8'h80;
  logic [2:0] gain = 3'd3;
  logic [9:0] ofs;
  logic lock, rst_o, gdec;

  int errs = 0, checks = 0, cyc = 0, target = 'h2A5, n_gdec = 0, n_rst = 0;
  string phase = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  offset_cal_ctrl #(.STEP_CYC(STEP), .WDOG_CYC(WD), .NOPEAK_EDGES(NP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp), .edge_i(edge_p), .edge_rise_i(rise),
    .min_i(mn), .max_i(mx), .min_vld_i(vmin), .max_vld_i(vmax), .peak_i(peak),
    .gain_i(gain), .gain_chg_i(gchg), .offset_o(ofs), .lock_o(lock),
    .restart_o(rst_o), .gain_dec_o(gdec)
  );

  // reference model
  int m_sar, m_trial, m_bit, m_step, m_run, m_wd, m_np, m_blank, m_first, m_fine;
  int m_pbig, m_pneg, m_rst, m_gdec, corr, span, a, d, fnx;

  function automatic int clamp_ofs(int v);
    if (v < 0) return 0;
    if (v > MAXO) return MAXO;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sar = 1; m_trial = 512; m_bit = 9; m_step = 0; m_run = 0; m_wd = 0; m_np = 0;
      m_blank = 0; m_first = 1; m_fine = 0; m_pbig = 0; m_pneg = 0; m_rst = 0; m_gdec = 0;
    end else begin
      m_rst = 0; m_gdec = 0;
      if (m_sar != 0) begin
        m_wd = 0; m_np = 0;
        if (m_step == STEP - 1) begin
          m_step = 0;
          if (!cmp) m_trial = m_trial - (1 << m_bit);
          if (m_bit == 0) begin
            m_sar = 0; m_run = m_trial; m_blank = 0; m_first = 1;
            m_fine = 0; m_pbig = 0; m_pneg = 0;
          end else begin
            m_bit = m_bit - 1;
            m_trial = m_trial + (1 << m_bit);
          end
        end else m_step = m_step + 1;
      end else if (!edge_p && m_wd == WD - 1) begin
        m_rst = 1; m_sar = 1; m_trial = 512; m_bit = 9; m_step = 0; m_wd = 0; m_np = 0;
      end else begin
        m_wd = edge_p ? 0 : m_wd + 1;
        if (peak) m_np = 0;
        else if (edge_p) begin
          if (m_np == NP - 1) begin m_np = 0; m_gdec = 1; end
          else m_np = m_np + 1;
        end
        if (gchg) begin
          m_blank = 2; m_pbig = 0;
        end else if (edge_p) begin
          d = 0;
          if (vmin || vmax) begin
            corr = int'(mn) + int'(mx) - 256;
            if (gain >= 3) corr = corr * (1 << (int'(gain) - 3));
            else corr = corr >>> (3 - int'(gain));
            span = (mx > mn) ? int'(mx) - int'(mn) : 0;
            fnx = (span < 8) ? 1 : (span > 16) ? 0 : m_fine;
            a = (corr < 0) ? -corr : corr;
            if (a < 8) d = 0;
            else if (fnx != 0 || a <= 16) d = (corr < 0) ? -1 : 1;
            else if (m_pbig != 0 && m_pneg == int'(corr < 0)) d = corr;
            else d = 0;
            m_fine = fnx; m_pbig = int'(a > 8); m_pneg = int'(corr < 0);
          end
          if (m_blank > 0) m_blank = m_blank - 1;
          else if (d != 0 && ((d > 0) == rise)) begin
            if (m_first != 0) m_first = 0;
            else begin m_run = clamp_ofs(m_run + d); m_blank = 1; end
          end
        end
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // per-cycle compare, comparator drive, watchdog
  always @(negedge clk) begin
    cyc++;
    cmp = (target >= int'(ofs));
    if (rst_n && !done) begin
      check(int'(ofs) == ((m_sar != 0) ? m_trial : m_run), phase, int'(ofs),
            (m_sar != 0) ? m_trial : m_run, "offset_o");
      check(int'(lock) == m_sar, phase, int'(lock), m_sar, "lock_o");
      check(int'(rst_o) == m_rst, phase, int'(rst_o), m_rst, "restart_o");
      check(int'(gdec) == m_gdec, phase, int'(gdec), m_gdec, "gain_dec_o");
      if (gdec) n_gdec++;
      if (rst_o) n_rst++;
    end
    if (cyc > 20000 && !done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
      finish_run();
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hit(bit r, int lo, int hi, bit pv, bit pk);
    rise = r; mn = 8'(lo); mx = 8'(hi); vmin = pv; vmax = pv; peak = pk; edge_p = 1'b1;
    @(negedge clk);
    edge_p = 1'b0; peak = 1'b0;
    idle(3);
  endtask

  task automatic new_gain(int g);
    gain = 3'(g); gchg = 1'b1;
    @(negedge clk);
    gchg = 1'b0;
    idle(2);
  endtask

  initial begin
    idle(2);
    // reset state (R1)
    check(lock == 1'b1, "R1", int'(lock), 1, "lock in reset");
    check(ofs == 10'h200, "R1", int'(ofs), 'h200, "trial in reset");
    rst_n = 1'b1;
    while (lock) @(negedge clk);
    check(int'(ofs) == 'h2A5, "R1", int'(ofs), 'h2A5, "search result");

    phase = "R8";
    hit(1, 'h70, 'h9C, 1, 1);               // +12, first update dropped
    check(int'(ofs) == 'h2A5, "R8", int'(ofs), 'h2A5, "first update discarded");
    hit(1, 'h70, 'h9C, 0, 1);               // no valid peak
    check(int'(ofs) == 'h2A5, "R8", int'(ofs), 'h2A5, "no valid peak");
    phase = "R3";
    hit(1, 'h70, 'h9C, 1, 1);
    check(int'(ofs) == 'h2A6, "R3", int'(ofs), 'h2A6, "one lsb step");
    phase = "R7";
    hit(1, 'h70, 'h9C, 1, 1);
    check(int'(ofs) == 'h2A6, "R7", int'(ofs), 'h2A6, "edge after update blocked");
    hit(1, 'h70, 'h9C, 1, 1);
    check(int'(ofs) == 'h2A7, "R7", int'(ofs), 'h2A7, "second edge updates");

    phase = "R6";
    hit(0, 'h70, 'h9C, 1, 1);
    hit(0, 'h70, 'h9C, 1, 1);
    check(int'(ofs) == 'h2A7, "R6", int'(ofs), 'h2A7, "positive shift on falling edge ignored");

    phase = "R5";
    for (int i = 0; i < 4; i++) hit(1, 'h70, 'hB0, 1, 1);
    for (int i = 0; i < 4; i++) hit(0, 'h40, 'h60, 1, 1);
    hit(1, 'h40, 'h60, 1, 1);

    phase = "R2";
    new_gain(5);
    for (int i = 0; i < 4; i++) hit(1, 'h70, 'h9C, 1, 1);
    new_gain(1);
    for (int i = 0; i < 4; i++) hit(1, 'h70, 'hB0, 1, 1);
    new_gain(0);
    for (int i = 0; i < 4; i++) hit(0, 'h40, 'h60, 1, 1);

    phase = "R4";
    new_gain(3);
    for (int i = 0; i < 4; i++) hit(1, 'hC0, 'hC4, 1, 1);
    for (int i = 0; i < 3; i++) hit(1, 'hB8, 'hC4, 1, 1);
    for (int i = 0; i < 4; i++) hit(1, 'hA0, 'hC8, 1, 1);

    phase = "R9";
    new_gain(7);
    for (int i = 0; i < 8; i++) hit(1, 'hE0, 'hFF, 1, 1);
    check(int'(ofs) == MAXO, "R9", int'(ofs), MAXO, "upper clamp");
    for (int i = 0; i < 8; i++) hit(0, 'h00, 'h20, 1, 1);
    check(int'(ofs) == 0, "R9", int'(ofs), 0, "lower clamp");

    phase = "R11";
    n_gdec = 0;
    for (int i = 0; i < 16; i++) hit(i % 2 == 0, 'h70, 'h9C, 0, 0);
    check(n_gdec == 1, "R11", n_gdec, 1, "decrement after 16 empty edges");
    for (int i = 0; i < 10; i++) hit(1, 'h70, 'h9C, 0, 0);
    peak = 1'b1; @(negedge clk); peak = 1'b0;
    for (int i = 0; i < 10; i++) hit(0, 'h70, 'h9C, 0, 0);
    check(n_gdec == 1, "R11", n_gdec, 1, "peak clears count");

    phase = "R10";
    target = 'h0F3; n_rst = 0;
    while (!rst_o) @(negedge clk);
    phase = "R12";
    hit(1, 'hE0, 'hFF, 1, 1);
    hit(0, 'h00, 'h20, 1, 1);
    while (lock) @(negedge clk);
    check(n_rst == 1, "R10", n_rst, 1, "one restart pulse");
    check(int'(ofs) == 'h0F3, "R10", int'(ofs), 'h0F3, "new search result");
    idle(3);
    done = 1;
    finish_run();
  end
endmodule